// File: doc/BRIEF.md
# Five-Pin GPIO Port with Clock-Out Override

This block is a small general-purpose I/O port on an 8-bit register bus. It holds an output latch and a direction register, and it drives per-pin `pad_out` and `pad_oe` signals toward external pad drivers. It reads back each pin either from the latch, when the pin is an output, or from a synchronized copy of the pad input, when the pin is an input. Writes are clocked. Reads are combinational from the bus address.

The direction register has one extra control bit in its most significant position. When that bit is set, pin 2 stops following its latch and direction bit. It drives the `clk_src` input and its output enable is forced on. Pin 2's latch bit can still be written while the override is active, and it takes effect again once the override is cleared. Each latch bit drives its pad output at all times, whatever the direction. A value written to the latch while the pin is still an input is therefore already present when the output enable rises.

Top module: `pio_port`

## Requirements
- R1: After reset, the direction bits, the clock-out enable and the output latch are all 0. `pad_oe` is 0, and a read of the direction register at address 0x06 returns 0x00.
- R2: A write to address 0x06 loads `bus_wdata[4:0]` into the direction bits. From the next cycle, `pad_oe[i]` equals direction bit i (1 = output, 0 = input) for every pin not taken by the clock override.
- R3: Bits 6:5 of the direction register are reserved. Writes to them are ignored and they read as 0. A read of 0x06 returns the clock-out enable in bit 7 and the direction bits in bits 4:0.
- R4: A write to address 0x02 loads `bus_wdata[4:0]` into the output latch. `pad_out[i]` follows latch bit i whatever the direction bit, except for pin 2 while the override is active.
- R5: A read of address 0x02 returns, in bit i, the latch bit when direction bit i is 1 and the synchronized pad input when it is 0. Bits 7:5 read as 0.
- R6: Pad inputs pass through two flops. A change on `pad_in` is visible in the read-back after the second rising clock edge and not after the first.
- R7: While bit 7 of the direction register is 1, `pad_out[2]` equals `clk_src` and `pad_oe[2]` is 1, regardless of direction bit 2 and latch bit 2.
- R8: Latch bit 2 stays writable while the override is active. Once the override is cleared, `pad_out[2]` shows the latch value written during the override, and `pad_oe[2]` again follows direction bit 2.
- R9: If the latch is written while a pin is an input, then in the first cycle the pin's direction bit is 1, `pad_out` already shows the latched value together with the raised `pad_oe`.
- R10: A write changes state only when `bus_we` is 1 and `bus_addr` is 0x02 or 0x06. Any other address has no effect and reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| clk_src | input | 1 | Clock routed to pin 2 when the override is enabled |
| pad_in | input | 5 | Raw pad input levels |
| pad_out | output | 5 | Output value per pin |
| pad_oe | output | 5 | Output driver enable per pin |

## Verification
The bench sets the latch while the pins are inputs and then raises the direction bits, checking output value and enable in the same sample. A design that gated the output with the enable would show a zero for one cycle there. It enables the clock override with direction bit 2 cleared and then sets latch bit 2 under the override. A design that ignored the override would leave pin 2 undriven, and one that blocked latch writes during the override would bring back a stale bit once it is cleared. It also measures the input synchronizer one edge at a time, to catch a missing or extra stage. It writes all ones to the reserved bits and to an unmapped address, which exposes any decoding that leaks into the direction register.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PIO_PINS     = 5;
    localparam int PIO_AW       = 8;
    localparam int PIO_DW       = 8;
    localparam int PIO_SYNC     = 2;
    localparam int PIO_CLK_PIN  = 2;
    localparam int PIO_CKEN_BIT = 7;
    localparam logic [PIO_AW-1:0] PIO_DIR_ADDR = 8'h06;
    localparam logic [PIO_AW-1:0] PIO_DAT_ADDR = 8'h02;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_DAT  = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(
        input logic [PIO_AW-1:0] addr,
        input logic [PIO_AW-1:0] dir_addr,
        input logic [PIO_AW-1:0] dat_addr
    );
        if (addr == dir_addr) return SEL_DIR;
        if (addr == dat_addr) return SEL_DAT;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            sync_d[s] = sync_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int NPINS    = PIO_PINS,
    parameter int DW       = PIO_DW,
    parameter int CKEN_BIT = PIO_CKEN_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             we,
    input  logic [DW-1:0]    wdata,
    output logic [NPINS-1:0] dir_o,
    output logic [NPINS-1:0] latch_o,
    output logic             cken_o
);

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] latch;
        logic             cken;
    } regs_t;

    regs_t r_d, r_q;

    // reserved bits between the direction field and the enable are never stored
    logic unused_wbits;
    assign unused_wbits = ^wdata[CKEN_BIT-1:NPINS];

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (sel)
                SEL_DIR: begin
                    r_d.dir  = wdata[NPINS-1:0];
                    r_d.cken = wdata[CKEN_BIT];
                end
                SEL_DAT: r_d.latch = wdata[NPINS-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dir_o   = r_q.dir;
    assign latch_o = r_q.latch;
    assign cken_o  = r_q.cken;

endmodule

// File: rtl/pio_pinmux.sv
module pio_pinmux #(
    parameter int NPINS   = 5,
    parameter int CLK_PIN = 2
) (
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] latch,
    input  logic [NPINS-1:0] sync_in,
    input  logic             cken,
    input  logic             clk_src,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] rd_pins
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        if (i == CLK_PIN) begin : g_clk
            always_comb begin
                pad_out[i] = cken ? clk_src : latch[i];
                pad_oe[i]  = cken | dir[i];
            end
        end else begin : g_std
            always_comb begin
                pad_out[i] = latch[i];
                pad_oe[i]  = dir[i];
            end
        end
        always_comb rd_pins[i] = dir[i] ? latch[i] : sync_in[i];
    end

endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int NPINS    = PIO_PINS,
    parameter int AW       = PIO_AW,
    parameter int DW       = PIO_DW,
    parameter int SYNC     = PIO_SYNC,
    parameter int CLK_PIN  = PIO_CLK_PIN,
    parameter int CKEN_BIT = PIO_CKEN_BIT,
    parameter logic [AW-1:0] DIR_ADDR = PIO_DIR_ADDR,
    parameter logic [AW-1:0] DAT_ADDR = PIO_DAT_ADDR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_we,
    output logic [DW-1:0]    bus_rdata,
    input  logic             clk_src,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    reg_sel_e         sel;
    logic [NPINS-1:0] dir, latch, sync_in, rd_pins;
    logic             cken;

    assign sel = decode_addr(bus_addr, DIR_ADDR, DAT_ADDR);

    pio_regs #(.NPINS(NPINS), .DW(DW), .CKEN_BIT(CKEN_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .we(bus_we), .wdata(bus_wdata),
        .dir_o(dir), .latch_o(latch), .cken_o(cken)
    );

    pio_sync #(.WIDTH(NPINS), .STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sync_in)
    );

    pio_pinmux #(.NPINS(NPINS), .CLK_PIN(CLK_PIN)) u_mux (
        .dir(dir), .latch(latch), .sync_in(sync_in), .cken(cken),
        .clk_src(clk_src), .pad_out(pad_out), .pad_oe(pad_oe), .rd_pins(rd_pins)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_DIR: begin
                bus_rdata[NPINS-1:0] = dir;
                bus_rdata[CKEN_BIT]  = cken;
            end
            SEL_DAT: bus_rdata[NPINS-1:0] = rd_pins;
            default: ;
        endcase
    end

endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
    import pio_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [PIO_AW-1:0]   bus_addr,
    input logic [PIO_DW-1:0]   bus_wdata,
    input logic                bus_we,
    input logic [PIO_DW-1:0]   bus_rdata,
    input logic [PIO_PINS-1:0] pad_out,
    input logic [PIO_PINS-1:0] pad_oe
);

    // R1
    reset_oe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pad_oe == '0);

    // R2
    dir_write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == PIO_DIR_ADDR) |=>
            pad_oe[1:0] == $past(bus_wdata[1:0]) && pad_oe[4:3] == $past(bus_wdata[4:3]));

    // R3
    dir_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == PIO_DIR_ADDR |-> bus_rdata[6:5] == 2'b00);

    // R4
    dat_write_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == PIO_DAT_ADDR) |=> pad_out[0] == $past(bus_wdata[0]));

    // R5
    dat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == PIO_DAT_ADDR |-> bus_rdata[7:5] == 3'b000);

    // R7
    clkout_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == PIO_DIR_ADDR && bus_wdata[PIO_CKEN_BIT]) |=> pad_oe[PIO_CLK_PIN]);

    // R10
    idle_oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_oe));

endmodule

bind pio_port pio_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_pio_port.sv
`timescale 1ns/1ps
module test_pio_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       clk_src = 1'b0;
    logic [4:0] pad_in = 5'h00;
    logic [4:0] pad_out;
    logic [4:0] pad_oe;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] A_DIR = 8'h06;
    localparam logic [7:0] A_DAT = 8'h02;

    always #2 clk = ~clk;

    pio_port i_pio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .clk_src(clk_src),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle_inputs();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1", "pad_oe after reset", {3'b0, pad_oe}, 8'h00);
        chk("R1", "pad_out after reset", {3'b0, pad_out}, 8'h00);
        rd(A_DIR, v); chk("R1", "direction read", v, 8'h00);
        rd(A_DAT, v); chk("R1", "data read", v, 8'h00);
    endtask

    task automatic t_dir();
        logic [7:0] v;
        wr(A_DIR, 8'h7F);
        chk("R2", "pad_oe all outputs", {3'b0, pad_oe}, 8'h1F);
        rd(A_DIR, v); chk("R3", "reserved bits dropped", v, 8'h1F);
        wr(A_DIR, 8'h0A);
        chk("R2", "pad_oe pattern", {3'b0, pad_oe}, 8'h0A);
        rd(A_DIR, v); chk("R3", "direction readback", v, 8'h0A);
    endtask

    task automatic t_data();
        logic [7:0] v;
        logic [4:0] latch = 5'h15, dirv = 5'h0A, pins = 5'h1B;
        wr(A_DAT, {3'b111, latch});
        chk("R4", "pad_out follows latch", {3'b0, pad_out}, {3'b0, latch});
        pad_in = pins;
        settle_inputs();
        rd(A_DAT, v);
        chk("R5", "mixed readback", v, {3'b0, (latch & dirv) | (pins & ~dirv)});
    endtask

    task automatic t_sync();
        logic [7:0] v;
        wr(A_DIR, 8'h00);
        pad_in = 5'h1F;
        settle_inputs();
        @(negedge clk);
        pad_in = 5'h0C;
        bus_addr = A_DAT;
        @(posedge clk); #1;
        chk("R6", "after one edge", bus_rdata, 8'h1F);
        @(posedge clk); #1;
        chk("R6", "after two edges", bus_rdata, 8'h0C);
    endtask

    task automatic t_clkout();
        logic [7:0] v;
        wr(A_DAT, 8'h00);
        wr(A_DIR, 8'h80);
        chk("R7", "pin2 oe forced", {3'b0, pad_oe}, 8'h04);
        rd(A_DIR, v); chk("R7", "enable readback", v, 8'h80);
        clk_src = 1'b1; #0.5;
        chk("R7", "pin2 drives clock high", {7'b0, pad_out[2]}, 8'h01);
        clk_src = 1'b0; #0.5;
        chk("R7", "pin2 drives clock low", {7'b0, pad_out[2]}, 8'h00);
        wr(A_DAT, 8'h04);
        clk_src = 1'b0; #0.5;
        chk("R7", "latch bit2 overridden", {7'b0, pad_out[2]}, 8'h00);
        wr(A_DIR, 8'h00);
        chk("R8", "pin2 back to latch", {7'b0, pad_out[2]}, 8'h01);
        chk("R8", "pin2 oe back to dir", {3'b0, pad_oe}, 8'h00);
    endtask

    task automatic t_glitch();
        wr(A_DIR, 8'h00);
        wr(A_DAT, 8'h1B);
        chk("R9", "latch visible while input", {3'b0, pad_out}, 8'h1B);
        @(negedge clk);
        bus_addr = A_DIR; bus_wdata = 8'h1F; bus_we = 1'b1;
        @(posedge clk); #0.5;
        bus_we = 1'b0;
        chk("R9", "oe rises", {3'b0, pad_oe}, 8'h1F);
        chk("R9", "value present with oe", {3'b0, pad_out}, 8'h1B);
    endtask

    task automatic t_decode();
        logic [7:0] v;
        wr(A_DIR, 8'h05);
        wr(A_DAT, 8'h09);
        wr(8'h03, 8'hFF);
        wr(8'h86, 8'hFF);
        chk("R10", "oe after unmapped write", {3'b0, pad_oe}, 8'h05);
        chk("R10", "out after unmapped write", {3'b0, pad_out}, 8'h09);
        rd(8'h03, v); chk("R10", "unmapped read", v, 8'h00);
        @(negedge clk);
        bus_addr = A_DIR; bus_wdata = 8'h9A; bus_we = 1'b0;
        @(negedge clk);
        rd(A_DIR, v); chk("R10", "no strobe no write", v, 8'h05);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir();
        t_data();
        t_sync();
        t_clkout();
        t_glitch();
        t_decode();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule